// File: doc/BRIEF.md
# Battery Switch Enable Controller

This block produces the three enable signals for the external switches of a battery pack: the charge path, the discharge path and the precharge path. Each output is built from software control bits, disable requests from the battery protection logic, and a power-off mode signal. A PWM input from a timer can be gated into the charge output, the precharge output, or both, so that charging can be pulsed. The PWM comes in as a plain signal, so no timer output pin has to be set up for it.

Software writes one control word and reads it back through a simple port. The protection logic always wins: software can only take enables away and cannot force a switch on against a protection disable. When a current protection event occurs, a hold-off timer counts `HOLD_TICKS` periods of a slow tick input. The default is 1000 periods of a 1 kHz tick, which is one second. While the timer runs, software cannot turn the charge or discharge switch on. The precharge path is on by default, and its control bit has disable sense, so a battery that is coming back from deep discharge or from power-off can be precharged before the main switches close.

Top module: `batt_switch_ctrl`

## Requirements
- R1: While `rst` is high, all three outputs are 0 and `rd_data` reads 0. In the first cycle after reset is released, `pre_en_o` is 1, and `chg_en_o` and `dis_en_o` are 0.
- R2: The control word has `chg_en` at bit 0 and `dis_en` at bit 1. Writing 1 to either bit enables that switch. Each output is registered: it reflects the control state and the inputs of the cycle before.
- R3: When `prot_chg_off` is 1, `chg_en_o` is 0 in the next cycle, whatever the control bits hold. When `prot_dis_off` is 1, `dis_en_o` is 0 in the next cycle in the same way.
- R4: Bit 2 (`pre_off`) has disable sense. When it is 0, the precharge output is on. When it is 1, the precharge output is off.
- R5: Bit 3 routes the PWM input to the charge output, and bit 4 routes it to the precharge output. Each bit acts on its own output only. A routed output is its gated enable ANDed with `pwm_in`. An output that is not routed follows its gated enable alone. The discharge output is never modulated.
- R6: While `pwr_off` is 1, all three outputs are 0 in the next cycle and writes are ignored. The control bits also return to their reset values. After `pwr_off` falls, the charge and discharge outputs stay off and the precharge output comes back on.
- R7: A `cur_prot_evt` pulse loads the hold-off timer with `HOLD_TICKS`. A new pulse while the timer runs reloads it. The timer decrements on each cycle in which `tick` is 1. Read-back bit 5 is 1 from the cycle after the pulse until the tick that brings the count to zero.
- R8: While bit 5 is 1, a write cannot change bit 0 or bit 1 from 0 to 1. It can still clear those bits, and it writes bits 2 to 4 normally.
- R9: `rd_data` returns the five control bits at positions 0 to 4 and the hold-off status at bit 5. The new value appears in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word to write |
| rd_data | output | 6 | Control bits and hold-off status |
| prot_chg_off | input | 1 | Protection disable for the charge switch |
| prot_dis_off | input | 1 | Protection disable for the discharge switch |
| cur_prot_evt | input | 1 | Current protection event pulse |
| pwr_off | input | 1 | Power-off mode |
| pwm_in | input | 1 | PWM signal from the timer |
| tick | input | 1 | Hold-off time base, one-cycle pulse |
| chg_en_o | output | 1 | Charge switch enable |
| dis_en_o | output | 1 | Discharge switch enable |
| pre_en_o | output | 1 | Precharge switch enable |

## Verification
The outputs are driven with every enable combination, and the protection disables are raised one at a time against enabled bits. This shows that software cannot override protection, and that each protection input reaches only its own switch. PWM routing is tried for the charge output alone, the precharge output alone and both together, with `pwm_in` held low and held high. This tells a missing route apart from a route crossed onto the wrong output, and shows that the discharge output is never modulated. The hold-off is probed just before and just after its last tick, with a blocked set, an allowed clear and a reload by a second event, and a power-off entry and exit checks that the precharge output comes back on alone.

// File: rtl/batt_sw_pkg.sv
package batt_sw_pkg;
  localparam int CTRL_W = 5;
  localparam int RD_W   = CTRL_W + 1;
  localparam int N_SW   = 3;
  localparam int SW_CHG = 0;
  localparam int SW_DIS = 1;
  localparam int SW_PRE = 2;

  typedef struct packed {
    logic pwm_pre;
    logic pwm_chg;
    logic pre_off;
    logic dis_en;
    logic chg_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '0;
endpackage

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int HOLD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic active
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= LOAD;
    else if (tick && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import batt_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              pwr_off,
  input  logic              lock,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;
  ctrl_t wr_val;

  always_comb begin
    wr_val = ctrl_t'(wr_data);
    if (lock) begin
      wr_val.chg_en = wr_val.chg_en & ctrl_q.chg_en;
      wr_val.dis_en = wr_val.dis_en & ctrl_q.dis_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_off)
      ctrl_q <= CTRL_RST;
    else if (wr_en)
      ctrl_q <= wr_val;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/fet_drive.sv
module fet_drive #(
  parameter bit HAS_PWM = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic prot_off,
  input  logic pwr_off,
  input  logic pwm_sel,
  input  logic pwm_in,
  output logic drv_en
);
  logic gated;
  logic nxt;

  assign gated = en_req & ~prot_off & ~pwr_off;

  generate
    if (HAS_PWM) begin : g_pwm
      assign nxt = gated & (pwm_sel ? pwm_in : 1'b1);
    end else begin : g_plain
      logic unused_sel;
      assign unused_sel = pwm_sel ^ pwm_in;
      assign nxt = gated;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) drv_en <= 1'b0;
    else     drv_en <= nxt;
  end
endmodule

// File: rtl/batt_switch_ctrl.sv
module batt_switch_ctrl
  import batt_sw_pkg::*;
#(
  parameter int HOLD_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [RD_W-1:0]   rd_data,
  input  logic              prot_chg_off,
  input  logic              prot_dis_off,
  input  logic              cur_prot_evt,
  input  logic              pwr_off,
  input  logic              pwm_in,
  input  logic              tick,
  output logic              chg_en_o,
  output logic              dis_en_o,
  output logic              pre_en_o
);
  localparam bit [N_SW-1:0] PWM_CAPABLE = 3'b101;

  ctrl_t           ctrl;
  logic            hold_active;
  logic [N_SW-1:0] req;
  logic [N_SW-1:0] prot;
  logic [N_SW-1:0] sel;
  logic [N_SW-1:0] drv;

  holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (cur_prot_evt),
    .tick   (tick),
    .active (hold_active)
  );

  ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pwr_off (pwr_off),
    .lock    (hold_active),
    .ctrl    (ctrl)
  );

  assign req[SW_CHG]  = ctrl.chg_en;
  assign req[SW_DIS]  = ctrl.dis_en;
  assign req[SW_PRE]  = ~ctrl.pre_off;
  assign prot[SW_CHG] = prot_chg_off;
  assign prot[SW_DIS] = prot_dis_off;
  assign prot[SW_PRE] = 1'b0;
  assign sel[SW_CHG]  = ctrl.pwm_chg;
  assign sel[SW_DIS]  = 1'b0;
  assign sel[SW_PRE]  = ctrl.pwm_pre;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    fet_drive #(.HAS_PWM(PWM_CAPABLE[i])) u_drv (
      .clk      (clk),
      .rst      (rst),
      .en_req   (req[i]),
      .prot_off (prot[i]),
      .pwr_off  (pwr_off),
      .pwm_sel  (sel[i]),
      .pwm_in   (pwm_in),
      .drv_en   (drv[i])
    );
  end

  assign chg_en_o = drv[SW_CHG];
  assign dis_en_o = drv[SW_DIS];
  assign pre_en_o = drv[SW_PRE];
  assign rd_data  = {hold_active, ctrl};
endmodule

// File: rtl/batt_switch_ctrl_chk.sv
module batt_switch_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] rd_data,
  input logic       prot_chg_off,
  input logic       prot_dis_off,
  input logic       cur_prot_evt,
  input logic       pwr_off,
  input logic       chg_en_o,
  input logic       dis_en_o,
  input logic       pre_en_o
);
  a_r3_prot_chg: assert property (@(posedge clk) disable iff (rst)
    prot_chg_off |=> !chg_en_o);
  a_r3_prot_dis: assert property (@(posedge clk) disable iff (rst)
    prot_dis_off |=> !dis_en_o);
  a_r6_pwroff_all_off: assert property (@(posedge clk) disable iff (rst)
    pwr_off |=> (!chg_en_o && !dis_en_o && !pre_en_o));
  a_r7_evt_starts_hold: assert property (@(posedge clk) disable iff (rst)
    cur_prot_evt |=> rd_data[5]);
  a_r8_no_set_chg: assert property (@(posedge clk) disable iff (rst)
    rd_data[5] |=> !$rose(rd_data[0]));
  a_r8_no_set_dis: assert property (@(posedge clk) disable iff (rst)
    rd_data[5] |=> !$rose(rd_data[1]));
endmodule

bind batt_switch_ctrl batt_switch_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_data      (rd_data),
  .prot_chg_off (prot_chg_off),
  .prot_dis_off (prot_dis_off),
  .cur_prot_evt (cur_prot_evt),
  .pwr_off      (pwr_off),
  .chg_en_o     (chg_en_o),
  .dis_en_o     (dis_en_o),
  .pre_en_o     (pre_en_o)
);

// File: tb/test_batt_switch_ctrl.sv
module test_batt_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [5:0] rd_data;
  logic prot_chg_off = 1'b0, prot_dis_off = 1'b0, cur_prot_evt = 1'b0;
  logic pwr_off = 1'b0, pwm_in = 1'b0, tick = 1'b0;
  logic chg_en_o, dis_en_o, pre_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_switch_ctrl #(.HOLD_TICKS(HOLD)) i_batt_switch_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .prot_chg_off(prot_chg_off), .prot_dis_off(prot_dis_off),
    .cur_prot_evt(cur_prot_evt), .pwr_off(pwr_off), .pwm_in(pwm_in),
    .tick(tick), .chg_en_o(chg_en_o), .dis_en_o(dis_en_o), .pre_en_o(pre_en_o)
  );

  // behavioural reference model
  int  m_ctrl = 0;
  int  m_cnt  = 0;
  bit  m_c = 0, m_d = 0, m_p = 0;

  always @(posedge clk) begin
    int nv;
    bit act;
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_c = 0; m_d = 0; m_p = 0;
    end else begin
      if (pwr_off) begin
        m_c = 0; m_d = 0; m_p = 0;
      end else begin
        m_c = m_ctrl[0] && !prot_chg_off && (m_ctrl[3] ? pwm_in : 1'b1);
        m_d = m_ctrl[1] && !prot_dis_off;
        m_p = !m_ctrl[2] && (m_ctrl[4] ? pwm_in : 1'b1);
      end
      act = (m_cnt != 0);
      if (pwr_off) m_ctrl = 0;
      else if (wr_en) begin
        nv = int'(wr_data);
        if (act) begin
          if (!m_ctrl[0]) nv[0] = 1'b0;
          if (!m_ctrl[1]) nv[1] = 1'b0;
        end
        m_ctrl = nv;
      end
      if (cur_prot_evt) m_cnt = HOLD;
      else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    logic [5:0] exp_rd;
    if (!done) begin
      exp_rd = {(m_cnt != 0), m_ctrl[4:0]};
      n_chk++;
      if (rd_data !== exp_rd || chg_en_o !== m_c || dis_en_o !== m_d || pre_en_o !== m_p) begin
        n_fail++;
        $display("FAIL model compare R2 R3 R4 R5 R6 R9: rd=%h c=%b d=%b p=%b expected rd=%h c=%b d=%b p=%b",
                 rd_data, chg_en_o, dis_en_o, pre_en_o, exp_rd, m_c, m_d, m_p);
      end
    end
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      cyc(3);
    end
  endtask

  function automatic logic [8:0] outs();
    return {6'd0, chg_en_o, dis_en_o, pre_en_o};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    check("R1 reset rd", {3'd0, rd_data}, 9'h000);
    check("R1 reset outs", outs(), 9'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset outs", outs(), 9'b001);

    wr(5'b00011); // R2 charge and discharge on
    check("R9 read-back", {3'd0, rd_data}, 9'h003);
    @(negedge clk);
    check("R2 both on", outs(), 9'b111);

    wr(5'b00111); @(negedge clk);
    check("R4 pre_off disables precharge", outs(), 9'b110);

    prot_chg_off = 1'b1; wr(5'b00011); @(negedge clk);
    check("R3 charge protection wins", outs(), 9'b011);
    prot_chg_off = 1'b0; prot_dis_off = 1'b1; cyc(2);
    check("R3 discharge protection wins", outs(), 9'b101);
    prot_dis_off = 1'b0;

    wr(5'b01011); pwm_in = 1'b0; cyc(2);
    check("R5 pwm to charge low", outs(), 9'b011);
    pwm_in = 1'b1; cyc(2);
    check("R5 pwm to charge high", outs(), 9'b111);
    wr(5'b10011); pwm_in = 1'b0; cyc(2);
    check("R5 pwm to precharge only", outs(), 9'b110);
    wr(5'b11011); cyc(2);
    check("R5 pwm to both low", outs(), 9'b010);
    pwm_in = 1'b1; cyc(2);
    check("R5 pwm to both high", outs(), 9'b111);

    pwr_off = 1'b1; wr(5'b00011); @(negedge clk);
    check("R6 power-off all off", outs(), 9'b000);
    check("R6 power-off control cleared", {3'd0, rd_data}, 9'h000);
    pwr_off = 1'b0; cyc(2);
    check("R6 wake precharge only", outs(), 9'b001);

    wr(5'b00011);
    @(negedge clk); cur_prot_evt = 1'b1;
    @(negedge clk); cur_prot_evt = 1'b0;
    check("R7 hold active after event", {8'd0, rd_data[5]}, 9'd1);
    wr(5'b00001); // clearing allowed
    check("R8 clear allowed during hold", {3'd0, rd_data}, 9'h21);
    wr(5'b10011); // set of bit1 blocked, bit4 written
    check("R8 set blocked during hold", {3'd0, rd_data}, 9'h31);
    ticks(500);
    @(negedge clk); cur_prot_evt = 1'b1;
    @(negedge clk); cur_prot_evt = 1'b0;
    ticks(HOLD - 1);
    check("R7 reload still active at last-but-one tick", {8'd0, rd_data[5]}, 9'd1);
    ticks(1);
    check("R7 hold ends after last tick", {8'd0, rd_data[5]}, 9'd0);
    wr(5'b00011);
    check("R8 set allowed after hold", {3'd0, rd_data}, 9'h03);
    cyc(3);
    finish_run();
  end
endmodule